// File: doc/BRIEF.md
# Time-Interleaved Multi-Channel Sample Packer

The block collects 32-bit samples from 128 parallel signal instances and merges them onto 16 output lanes, each 64 bits wide. The fabric clock is four times the per-instance sample rate. Each lane therefore serves four time slots in turn. In each slot a lane emits one beat that carries two samples, so a lane covers eight instances over one cycle of the slot counter. Consecutive beats on a lane come from different instances, not from one instance in a contiguous run.

Each instance writes into its own holding register whenever its valid strobe is high. A free-running 2-bit slot counter selects which pair of holding registers each lane reads in the current cycle. A lane sends a beat only when both samples of the pair are new, meaning each has been written since it was last sent. The input rate is fixed, so the block never stalls. A beat that meets a low ready is lost and the lane raises an overflow pulse.

Top module: `ti_sample_packer`

## Requirements
- R1: While rst_n is low, and in the cycle after a reset edge, out_valid and out_ovf are all zero and out_slot is 0.
- R2: After reset, out_slot advances by one (mod 4) on every clock and names the slot whose beats are being presented.
- R3: A beat on lane L in slot s carries instance 32*s+L in bits [31:0] and instance 32*s+16+L in bits [63:32].
- R4: A lane's out_valid is high only when both samples of its pair have been captured since that pair was last emitted. Emitting a pair clears both of its halves, unless new samples arrive in the same cycle.
- R5: A beat carries the most recently captured sample of each of its two instances. A later strobe overwrites a sample that has not yet been sent.
- R6: out_ovf[L] is high in the cycle after a cycle in which out_valid[L] was high while out_ready[L] was low. That beat is dropped and is not presented again.
- R7: out_ready has no effect on the sequence of slots, valids or data. The block never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 4096 | Sample of instance i at bits [32*i+31:32*i] |
| in_valid | input | 128 | Sample strobe, one bit per instance |
| out_data | output | 1024 | Beat of lane L at bits [64*L+63:64*L] |
| out_valid | output | 16 | Beat valid per lane |
| out_ready | input | 16 | Downstream ready per lane |
| out_ovf | output | 16 | Overflow pulse per lane: a beat was dropped |
| out_slot | output | 2 | Slot index of the beats being presented |

## Verification
The hardest case to reach is a pair in which only one half is new, because with strobes that all arrive together every pair fills at once. To reach it, the bench first empties every pair with one full strobe followed by a quiet wait. It then strobes only the even-half instances and checks that no beat appears. Random per-instance strobes create further half-filled pairs. A stretch with ready held low exposes the drop and overflow path while the bench confirms that the beat stream continues unchanged.

// File: rtl/ti_pack_pkg.sv
package ti_pack_pkg;
  // instance index served by (slot, half, lane)
  function automatic int inst_of(int slot, int half, int lane, int lanes, int spb);
    return (slot * spb + half) * lanes + lane;
  endfunction

  function automatic int lane_of(int inst, int lanes);
    return inst % lanes;
  endfunction

  function automatic int slot_of(int inst, int lanes, int spb);
    return inst / (lanes * spb);
  endfunction
endpackage

// File: rtl/ti_slot_counter.sv
module ti_slot_counter #(
  parameter int SLOTS = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot
);
  always_ff @(posedge clk) begin
    if (!rst_n) slot <= '0;
    else if (int'(slot) == SLOTS - 1) slot <= '0;
    else slot <= slot + 1'b1;
  end
endmodule

// File: rtl/ti_sample_bank.sv
module ti_sample_bank #(
  parameter int N_INST = 128,
  parameter int SAMP_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_INST*SAMP_W-1:0]      in_data,
  input  logic [N_INST-1:0]             in_valid,
  input  logic [N_INST-1:0]             take,
  output logic [N_INST-1:0][SAMP_W-1:0] hold,
  output logic [N_INST-1:0]             fresh
);
  for (genvar i = 0; i < N_INST; i++) begin : g_inst
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold[i]  <= '0;
        fresh[i] <= 1'b0;
      end else if (in_valid[i]) begin
        hold[i]  <= in_data[i*SAMP_W +: SAMP_W];
        fresh[i] <= 1'b1;
      end else if (take[i]) begin
        fresh[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ti_lane_packer.sv
module ti_lane_packer #(
  parameter int SAMP_W = 32,
  localparam int BEAT_W = 2 * SAMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SAMP_W-1:0] even_d,
  input  logic [SAMP_W-1:0] odd_d,
  input  logic              even_f,
  input  logic              odd_f,
  input  logic              ready,
  output logic              fire,
  output logic [BEAT_W-1:0] q_data,
  output logic              q_valid,
  output logic              q_ovf
);
  assign fire = even_f & odd_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_data  <= '0;
      q_valid <= 1'b0;
      q_ovf   <= 1'b0;
    end else begin
      q_data  <= {odd_d, even_d};
      q_valid <= fire;
      q_ovf   <= q_valid & ~ready;
    end
  end
endmodule

// File: rtl/ti_sample_packer.sv
module ti_sample_packer #(
  parameter int N_INST = 128,
  parameter int SAMP_W = 32,
  parameter int SLOTS  = 4,
  localparam int SPB    = 2,
  localparam int LANES  = N_INST / (SLOTS * SPB),
  localparam int BEAT_W = SPB * SAMP_W,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_INST*SAMP_W-1:0] in_data,
  input  logic [N_INST-1:0]        in_valid,
  output logic [LANES*BEAT_W-1:0]  out_data,
  output logic [LANES-1:0]         out_valid,
  input  logic [LANES-1:0]         out_ready,
  output logic [LANES-1:0]         out_ovf,
  output logic [SLOT_W-1:0]        out_slot
);
  import ti_pack_pkg::*;

  logic [SLOT_W-1:0]             slot;
  logic [N_INST-1:0][SAMP_W-1:0] hold;
  logic [N_INST-1:0]             fresh;
  logic [N_INST-1:0]             take;
  logic [LANES-1:0]              fire;

  ti_slot_counter #(.SLOTS(SLOTS)) u_slot (.clk(clk), .rst_n(rst_n), .slot(slot));

  ti_sample_bank #(.N_INST(N_INST), .SAMP_W(SAMP_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .take(take), .hold(hold), .fresh(fresh)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SAMP_W-1:0] even_d, odd_d;
    logic              even_f, odd_f;
    always_comb begin
      even_d = hold[inst_of(int'(slot), 0, l, LANES, SPB)];
      odd_d  = hold[inst_of(int'(slot), 1, l, LANES, SPB)];
      even_f = fresh[inst_of(int'(slot), 0, l, LANES, SPB)];
      odd_f  = fresh[inst_of(int'(slot), 1, l, LANES, SPB)];
    end
    ti_lane_packer #(.SAMP_W(SAMP_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .even_d(even_d), .odd_d(odd_d),
      .even_f(even_f), .odd_f(odd_f), .ready(out_ready[l]), .fire(fire[l]),
      .q_data(out_data[l*BEAT_W +: BEAT_W]), .q_valid(out_valid[l]), .q_ovf(out_ovf[l])
    );
  end

  // an emitted pair releases the fresh mark of both its instances
  for (genvar i = 0; i < N_INST; i++) begin : g_take
    assign take[i] = fire[lane_of(i, LANES)] && (int'(slot) == slot_of(i, LANES, SPB));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_slot <= '0;
    else out_slot <= slot;
  end
endmodule

// File: rtl/ti_sample_packer_chk.sv
module ti_sample_packer_chk #(
  parameter int N_INST = 128,
  parameter int LANES  = 16,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_INST-1:0] in_valid,
  input logic [N_INST-1:0] take,
  input logic [N_INST-1:0] fresh,
  input logic [LANES-1:0]  out_valid,
  input logic [LANES-1:0]  out_ready,
  input logic [LANES-1:0]  out_ovf,
  input logic [SLOT_W-1:0] out_slot
);
  logic [1:0] up;
  always_ff @(posedge clk) begin
    if (!rst_n) up <= '0;
    else up <= {up[0], 1'b1};
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (out_valid == '0 && out_ovf == '0)); // R1
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    up[1] |-> out_slot == SLOT_W'($past(out_slot) + 1'b1)); // R2
  AST_BEAT_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    up[0] |-> $countones($past(take)) == 2 * $countones(out_valid)); // R4
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    up[0] |-> ($past(take & ~in_valid) & fresh) == '0); // R4
  AST_CAPTURE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    up[0] |-> ($past(in_valid) & ~fresh) == '0); // R5
  AST_NO_OVERFLOW_WITHOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    up[0] |-> (out_ovf & ~$past(out_valid & ~out_ready)) == '0); // R6
endmodule

bind ti_sample_packer ti_sample_packer_chk #(.N_INST(N_INST), .LANES(LANES), .SLOT_W(SLOT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .take(take), .fresh(fresh),
  .out_valid(out_valid), .out_ready(out_ready), .out_ovf(out_ovf), .out_slot(out_slot)
);

// File: tb/test_ti_sample_packer.sv
module test_ti_sample_packer;
  localparam int NI = 128, SW = 32, NL = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NI*SW-1:0]  in_data = '0;
  logic [NI-1:0]     in_valid = '0;
  logic [NL*64-1:0]  out_data;
  logic [NL-1:0]     out_valid, out_ready = '1, out_ovf;
  logic [1:0]        out_slot;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ti_sample_packer i_ti_sample_packer (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_ovf(out_ovf), .out_slot(out_slot)
  );

  // reference: which instance a (slot, half, lane) beat half carries (R3)
  function automatic int src(int s, int h, int l);
    return 32 * s + 16 * h + l;
  endfunction

  logic [SW-1:0] m_hold [NI];
  bit            m_new  [NI];
  int            m_cnt;
  logic [63:0]   e_data [NL];
  bit            e_val  [NL];
  bit            e_ovf  [NL];
  int            e_slot;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NI; i++) begin m_hold[i] = '0; m_new[i] = 0; end
      for (int l = 0; l < NL; l++) begin e_val[l] = 0; e_ovf[l] = 0; end
      m_cnt = 0; e_slot = 0;
    end else begin
      for (int l = 0; l < NL; l++) begin
        int a, b;
        e_ovf[l] = e_val[l] && !out_ready[l];
        a = src(m_cnt, 0, l); b = src(m_cnt, 1, l);
        e_val[l]  = m_new[a] && m_new[b];
        e_data[l] = {m_hold[b], m_hold[a]};
        if (e_val[l]) begin m_new[a] = 0; m_new[b] = 0; end
      end
      for (int i = 0; i < NI; i++)
        if (in_valid[i]) begin m_hold[i] = in_data[i*SW +: SW]; m_new[i] = 1; end
      e_slot = m_cnt;
      m_cnt = (m_cnt + 1) % 4;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_cycle(string dreq);
    int nv = 0;
    chk(int'(out_slot) == e_slot, "R2", "slot", out_slot, e_slot);
    for (int l = 0; l < NL; l++) begin
      chk(out_ovf[l] == e_ovf[l], "R6", $sformatf("ovf lane %0d", l), out_ovf[l], e_ovf[l]);
      chk(out_valid[l] == e_val[l], "R4", $sformatf("valid lane %0d", l), out_valid[l], e_val[l]);
      if (e_val[l] && out_valid[l]) begin
        nv++;
        chk(out_data[l*64 +: 64] == e_data[l], dreq, $sformatf("data lane %0d", l),
            out_data[l*64 +: 64], e_data[l]);
      end
    end
  endtask

  task automatic tick(string dreq);
    @(posedge clk); @(negedge clk);
    check_cycle(dreq);
  endtask

  task automatic strobe(bit [NI-1:0] mask);
    in_valid = mask;
    for (int i = 0; i < NI; i++) in_data[i*SW +: SW] = $urandom;
  endtask

  bit [NI-1:0] even_mask;
  int cnt_v, cnt_o, t;

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NI; i++) even_mask[i] = ((i / 16) % 2 == 0);
    repeat (3) @(negedge clk);
    chk(out_valid == '0 && out_ovf == '0 && out_slot == 2'd0, "R1", "reset state",
        {out_valid, out_ovf}, 0);
    rst_n = 1'b1;
    tick("R3");
    chk(out_valid == '0 && out_slot == 2'd0, "R1", "first cycle after reset", out_valid, 0);

    // aligned strobes every 4 cycles, ready high
    for (int c = 0; c < 200; c++) begin
      if (c % 4 == 0) strobe('1); else in_valid = '0;
      tick("R3");
    end

    // random per-instance strobes and random ready
    for (int c = 0; c < 3000; c++) begin
      bit [NI-1:0] m;
      for (int i = 0; i < NI; i++) m[i] = ($urandom % 3 == 0);
      strobe(m);
      out_ready = NL'($urandom);
      tick("R5");
    end
    out_ready = '1;

    // R4 directed: flush all pairs, then only even halves
    strobe('1); tick("R3");
    in_valid = '0; repeat (8) tick("R3");
    cnt_v = 0;
    for (int c = 0; c < 40; c++) begin
      if (c % 4 == 0) strobe(even_mask); else in_valid = '0;
      tick("R4");
      if (out_valid != '0) cnt_v++;
    end
    chk(cnt_v == 0, "R4", "beats with one half missing", cnt_v, 0);

    // R5 directed: instance 0 overwritten before its pair is sent
    in_valid = '0;
    in_valid[0] = 1'b1; in_valid[16] = 1'b1;
    in_data[0 +: SW] = 32'h1111_1111; in_data[16*SW +: SW] = 32'h2222_2222;
    // wait until slot 0 pickup has just passed so the pair cannot go yet
    while (out_slot != 2'd3) tick("R5");
    tick("R5");
    in_valid = '0; in_valid[0] = 1'b1; in_data[0 +: SW] = 32'h3333_3333;
    tick("R5");
    in_valid = '0;
    t = 0;
    while (!(out_valid[0] && out_slot == 2'd0) && t < 8) begin tick("R5"); t++; end
    chk(out_data[63:0] == 64'h2222_2222_3333_3333, "R5", "latest sample kept",
        out_data[63:0], 64'h2222_2222_3333_3333);

    // ready low: beats keep flowing and are dropped
    out_ready = '0; cnt_v = 0; cnt_o = 0;
    for (int c = 0; c < 60; c++) begin
      if (c % 4 == 0) strobe('1); else in_valid = '0;
      tick("R7");
      if (out_valid != '0) cnt_v++;
      if (out_ovf != '0) cnt_o++;
    end
    chk(cnt_v >= 50, "R7", "beats presented with ready low", cnt_v, 50);
    chk(cnt_o >= 50, "R6", "overflow pulses", cnt_o, 50);
    out_ready = '1; in_valid = '0;
    tick("R6");
    tick("R6");
    chk(out_ovf == '0, "R6", "overflow clears after ready returns", out_ovf, 0);

    // reset in mid-stream
    rst_n = 1'b0; @(posedge clk); @(negedge clk);
    chk(out_valid == '0 && out_ovf == '0 && out_slot == 2'd0, "R1", "reset mid-stream",
        {out_valid, out_ovf}, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 16; c++) begin
      if (c % 4 == 1) strobe('1); else in_valid = '0;
      tick("R3");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule